// File: doc/BRIEF.md
# Receive Ring Buffer Frame Writer

This block sits between a receive MAC byte stream and a local packet memory. Each frame it accepts is stored in a circular buffer made of 256-byte pages. The buffer spans the pages from a configured first page up to, but not including, a configured end page. Storage begins at the current page. The first four bytes of that page are reserved for a per-frame header. The payload follows the header and wraps from the end of the ring back to its first page.

Before it takes the first byte of a frame, the block decides whether the ring has room. It compares the current page with the boundary page, which is the oldest page the host has not yet released. It also refuses frames while the halt input is set. Frames shorter than the minimum are padded with zeros. The header is written only after the last payload byte, so the host never sees a valid header in front of a partly stored frame. The block then advances the current page to the first page after the frame and raises a one-cycle receive-done pulse.

The host can load the current page through a load strobe while the block is idle. The page registers are assumed to be 8 bits wide, because the next-page value is stored in a single header byte.

Top module: `rxr_ring_writer`

## Requirements
- R1: `s_ready` is high only while the block is idle with room available, or while it is in the middle of accepting a frame. It is low from the cycle after the last byte is accepted until the header is complete. It is low one cycle after `halt` is set.
- R2: Free space is counted in pages. It is (boundary − current) when current < boundary, and (end − first) − (current − boundary) otherwise, so current = boundary counts as an empty ring. The block is idle-ready only when free space × 256 ≥ 1518 bytes. With a 12-page ring, 5 free pages refuse a frame and 6 free pages accept one.
- R3: A frame shorter than 60 bytes is stored as 60 bytes. The missing bytes are zeros and follow the received bytes.
- R4: Payload byte k is written to ring address current×256 + 4 + k. When the address reaches end×256, it continues at first×256.
- R5: Header byte 2 holds the low byte of the stored length and header byte 3 holds the high byte. The stored length is the padded frame length plus 4.
- R6: Header byte 0 is the status byte. Bit 0 is always 1. Bit 5 is a copy of bit 0 of the first received byte, which marks a group address. All other bits are 0.
- R7: Header byte 1 is the next page, computed as N = current×256 + ((L + 8 + 255) with its low 8 bits cleared), where L is the padded length. If N ≥ end×256, the ring size (end − first)×256 is subtracted. The stored value is N / 256.
- R8: The four header bytes, at current×256 + 0..3 in order, are the last four memory writes of a frame. Every payload and pad byte is written before them.
- R9: In the cycle after the last header byte is written, `cur_pg` equals the next page and `rx_done` is high for exactly one cycle per frame.
- R10: While reset is held, `s_ready`, `mem_we` and `rx_done` are 0 and `cur_pg` is 0.
- R11: A `cur_ld` strobe while the block is idle loads `cur_ld_pg` into `cur_pg` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_pg | input | 8 | First page of the ring |
| stop_pg | input | 8 | Page one past the end of the ring |
| bnd_pg | input | 8 | Boundary page (oldest page still held by the host) |
| halt | input | 1 | Refuse new frames while high |
| cur_ld | input | 1 | Load strobe for the current page |
| cur_ld_pg | input | 8 | Value loaded into the current page |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the last byte of a frame |
| s_ready | output | 1 | Block accepts the stream byte |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | 16 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| cur_pg | output | 8 | Current page register |
| rx_done | output | 1 | One-cycle pulse when a frame is complete |

## Verification
The assertions assume the following about the inputs:
- the first page is below the end page;
- the current and boundary pages lie inside the ring;
- the page registers do not change while a frame is being written;
- no frame is longer than 1514 bytes.

The stimulus holds to all of this. The ring limits are fixed for the whole run. Before each frame the boundary is set equal to the expected current page, which gives an empty ring, and frame lengths are drawn between 1 and 1514. The space tests move only the current and boundary pages, and only while no frame is in progress.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_PAD,
    ST_HDR,
    ST_SETL
  } wr_state_e;

  localparam logic [7:0] STAT_OK        = 8'h01;
  localparam int         STAT_GROUP_BIT = 5;
  localparam int         HDR_BYTES      = 4;
  localparam int         CRC_BYTES      = 4;
endpackage

// File: rtl/rxr_space.sv
module rxr_space #(
  parameter int PG_W       = 8,
  parameter int PAGE_BITS  = 8,
  parameter int NEED_BYTES = 1518
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PG_W-1:0] start_pg,
  input  logic [PG_W-1:0] stop_pg,
  input  logic [PG_W-1:0] bnd_pg,
  input  logic [PG_W-1:0] cur_pg,
  input  logic            halt,
  output logic            room_q
);
  localparam int SW      = PG_W + 2;
  localparam int NEED_PG = (NEED_BYTES + (1 << PAGE_BITS) - 1) >> PAGE_BITS;

  logic signed [SW-1:0] ring_pg, avail_pg;
  logic                 room_d;

  always_comb begin
    ring_pg = $signed({2'b00, stop_pg}) - $signed({2'b00, start_pg});
    if (cur_pg < bnd_pg)
      avail_pg = $signed({2'b00, bnd_pg}) - $signed({2'b00, cur_pg});
    else
      avail_pg = ring_pg - ($signed({2'b00, cur_pg}) - $signed({2'b00, bnd_pg}));
    room_d = !halt && (avail_pg >= $signed(SW'(NEED_PG)));
  end

  always_ff @(posedge clk) begin
    if (rst) room_q <= 1'b0;
    else     room_q <= room_d;
  end

  AST_HALT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    halt |=> !room_q); // R1
endmodule

// File: rtl/rxr_next_pg.sv
module rxr_next_pg #(
  parameter int PG_W      = 8,
  parameter int PAGE_BITS = 8,
  parameter int CNT_W     = 11,
  parameter int EXTRA     = 8
) (
  input  logic [PG_W-1:0]  base_pg,
  input  logic [PG_W-1:0]  start_pg,
  input  logic [PG_W-1:0]  stop_pg,
  input  logic [CNT_W-1:0] len,
  output logic [PG_W-1:0]  nxt_pg
);
  localparam int TW = CNT_W + 2;

  logic [TW-1:0]   tot;
  logic [PG_W:0]   pages, sum, ring;

  always_comb begin
    tot   = TW'(len) + TW'(EXTRA) + TW'((1 << PAGE_BITS) - 1);
    pages = (PG_W + 1)'(tot >> PAGE_BITS);
    sum   = {1'b0, base_pg} + pages;
    ring  = {1'b0, stop_pg} - {1'b0, start_pg};
    if (sum >= {1'b0, stop_pg}) sum = sum - ring;
    nxt_pg = sum[PG_W-1:0];
  end
endmodule

// File: rtl/rxr_wrap.sv
module rxr_wrap #(
  parameter int PG_W      = 8,
  parameter int PAGE_BITS = 8,
  localparam int ADDR_W   = PG_W + PAGE_BITS
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [PG_W-1:0]   start_pg,
  input  logic [PG_W-1:0]   stop_pg,
  output logic [ADDR_W-1:0] addr_out
);
  logic [ADDR_W-1:0] inc;

  always_comb begin
    inc = addr_in + ADDR_W'(1);
    if (inc == {stop_pg, {PAGE_BITS{1'b0}}})
      addr_out = {start_pg, {PAGE_BITS{1'b0}}};
    else
      addr_out = inc;
  end
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
  import rxr_pkg::*;
#(
  parameter int PG_W      = 8,
  parameter int PAGE_BITS = 8,
  parameter int MAX_FRAME = 1514,
  parameter int MIN_FRAME = 60,
  parameter int RESET_PG  = 0,
  localparam int ADDR_W   = PG_W + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PG_W-1:0]   start_pg,
  input  logic [PG_W-1:0]   stop_pg,
  input  logic [PG_W-1:0]   bnd_pg,
  input  logic              halt,
  input  logic              cur_ld,
  input  logic [PG_W-1:0]   cur_ld_pg,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [PG_W-1:0]   cur_pg,
  output logic              rx_done
);
  localparam int CNT_W = $clog2(MAX_FRAME + 1);
  localparam int NEED  = MAX_FRAME + CRC_BYTES;

  wr_state_e         st;
  logic [PG_W-1:0]   base_pg, cur_pg_q, nxt_pg;
  logic [ADDR_W-1:0] wa, first_addr, step_in, step_out;
  logic [CNT_W-1:0]  cnt, cnt_inc;
  logic [1:0]        hidx;
  logic              grp, room_q, accept;
  logic [15:0]       stored_len;
  logic [7:0]        hdr_byte;

  rxr_space #(.PG_W(PG_W), .PAGE_BITS(PAGE_BITS), .NEED_BYTES(NEED)) u_space (
    .clk(clk), .rst(rst), .start_pg(start_pg), .stop_pg(stop_pg),
    .bnd_pg(bnd_pg), .cur_pg(cur_pg_q), .halt(halt), .room_q(room_q));

  rxr_next_pg #(.PG_W(PG_W), .PAGE_BITS(PAGE_BITS), .CNT_W(CNT_W),
                .EXTRA(HDR_BYTES + CRC_BYTES)) u_next (
    .base_pg(base_pg), .start_pg(start_pg), .stop_pg(stop_pg),
    .len(cnt), .nxt_pg(nxt_pg));

  rxr_wrap #(.PG_W(PG_W), .PAGE_BITS(PAGE_BITS)) u_wrap (
    .addr_in(step_in), .start_pg(start_pg), .stop_pg(stop_pg),
    .addr_out(step_out));

  assign s_ready    = (st == ST_DATA) || (st == ST_IDLE && room_q);
  assign accept     = s_valid && s_ready;
  assign first_addr = {cur_pg_q, PAGE_BITS'(HDR_BYTES)};
  assign step_in    = (st == ST_IDLE) ? first_addr : wa;
  assign cnt_inc    = cnt + CNT_W'(1);
  assign stored_len = 16'(cnt) + 16'(HDR_BYTES);
  assign cur_pg     = cur_pg_q;

  always_comb begin
    case (hidx)
      2'd0:    hdr_byte = STAT_OK | (8'(grp) << STAT_GROUP_BIT);
      2'd1:    hdr_byte = 8'(nxt_pg);
      2'd2:    hdr_byte = stored_len[7:0];
      default: hdr_byte = stored_len[15:8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      wa        <= '0;
      base_pg   <= '0;
      cnt       <= '0;
      grp       <= 1'b0;
      hidx      <= '0;
      cur_pg_q  <= PG_W'(RESET_PG);
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rx_done   <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      rx_done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cur_ld) cur_pg_q <= cur_ld_pg;
          if (accept) begin
            base_pg   <= cur_pg_q;
            mem_we    <= 1'b1;
            mem_addr  <= first_addr;
            mem_wdata <= s_data;
            wa        <= step_out;
            grp       <= s_data[0];
            cnt       <= CNT_W'(1);
            hidx      <= '0;
            if (s_last) st <= (MIN_FRAME > 1) ? ST_PAD : ST_HDR;
            else        st <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (accept) begin
            mem_we    <= 1'b1;
            mem_addr  <= wa;
            mem_wdata <= s_data;
            wa        <= step_out;
            cnt       <= cnt_inc;
            if (s_last) st <= (cnt_inc < CNT_W'(MIN_FRAME)) ? ST_PAD : ST_HDR;
          end
        end
        ST_PAD: begin
          mem_we    <= 1'b1;
          mem_addr  <= wa;
          mem_wdata <= 8'h00;
          wa        <= step_out;
          cnt       <= cnt_inc;
          if (cnt_inc >= CNT_W'(MIN_FRAME)) st <= ST_HDR;
        end
        ST_HDR: begin
          mem_we    <= 1'b1;
          mem_addr  <= {base_pg, PAGE_BITS'(hidx)};
          mem_wdata <= hdr_byte;
          hidx      <= hidx + 2'd1;
          if (hidx == 2'd3) begin
            cur_pg_q <= nxt_pg;
            rx_done  <= 1'b1;
            st       <= ST_SETL;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PAD) |=> (mem_we && mem_wdata == 8'h00)); // R3
  AST_PAYLOAD_IN_RING: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DATA && accept) |=> (mem_addr >= {start_pg, {PAGE_BITS{1'b0}}} &&
                                   mem_addr <  {stop_pg,  {PAGE_BITS{1'b0}}})); // R4
  AST_HDR_AFTER_PAD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HDR) |-> (cnt >= CNT_W'(MIN_FRAME))); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done); // R9
  AST_DONE_AFTER_HDR: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> $past(st == ST_HDR && hidx == 2'd3)); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready && s_last) |=> !s_ready); // R1
endmodule

// File: tb/sim_rxr_ring_writer.sv
module sim_rxr_ring_writer;
  localparam int START = 8'h40;
  localparam int STOP  = 8'h4C;

  logic        clk, rst, halt, cur_ld, s_valid, s_last;
  logic [7:0]  start_pg, stop_pg, bnd_pg, cur_ld_pg, s_data;
  logic        s_ready, mem_we, rx_done;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, cur_pg;

  rxr_ring_writer u0 (
    .clk(clk), .rst(rst), .start_pg(start_pg), .stop_pg(stop_pg),
    .bnd_pg(bnd_pg), .halt(halt), .cur_ld(cur_ld), .cur_ld_pg(cur_ld_pg),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cur_pg(cur_pg), .rx_done(rx_done));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int         vecs = 0, errs = 0, done_cnt = 0, exp_cur;
  bit         dbl = 0, prev_done = 0;
  logic [7:0] bmem [int];
  int         wlog [$];

  always @(negedge clk) begin
    if (mem_we) begin
      bmem[int'(mem_addr)] = mem_wdata;
      wlog.push_back(int'(mem_addr));
    end
    if (rx_done) begin
      done_cnt++;
      if (prev_done) dbl = 1;
    end
    prev_done = rx_done;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int rd(input int a);
    return bmem.exists(a) ? int'(bmem[a]) : -1;
  endfunction

  function automatic int exp_next(input int base_pg, input int plen);
    int n;
    n = base_pg * 256 + ((plen + 8 + 255) & ~255);
    if (n >= STOP * 256) n -= (STOP - START) * 256;
    return n >> 8;
  endfunction

  task automatic send_frame(input int len, input bit grp);
    logic [7:0] q [$];
    int old, t, plen, nxt, base, a, e;
    bit okp, okd;
    for (int i = 0; i < len; i++) q.push_back(8'($urandom));
    q[0] = {q[0][7:1], grp};
    @(negedge clk);
    bnd_pg = 8'(exp_cur);
    repeat (2) @(negedge clk);
    bmem.delete();
    wlog.delete();
    dbl = 0;
    old = done_cnt;
    for (int i = 0; i < len; i++) begin
      bit r;
      if (i != 0) @(negedge clk);
      s_valid = 1'b1; s_data = q[i]; s_last = (i == len - 1);
      forever begin
        r = s_ready;
        @(posedge clk);
        if (r) break;
        @(negedge clk);
      end
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
    chk(s_ready == 1'b0, "R1 ready low after last byte", int'(s_ready), 0);
    t = 0;
    while (done_cnt == old && t < 4000) begin @(negedge clk); t++; end
    @(negedge clk);
    plen = (len < 60) ? 60 : len;
    nxt  = exp_next(exp_cur, plen);
    base = exp_cur * 256;
    chk(rd(base) == (1 | (int'(grp) << 5)), "R6 status byte", rd(base), 1 | (int'(grp) << 5));
    chk(rd(base + 1) == nxt, "R7 next page", rd(base + 1), nxt);
    chk(rd(base + 2) == ((plen + 4) & 255), "R5 length low", rd(base + 2), (plen + 4) & 255);
    chk(rd(base + 3) == ((plen + 4) >> 8), "R5 length high", rd(base + 3), (plen + 4) >> 8);
    a = base + 4; okp = 1; okd = 1;
    for (int i = 0; i < plen; i++) begin
      e = (i < len) ? int'(q[i]) : 0;
      if (rd(a) != e) begin
        if (i < len) okd = 0; else okp = 0;
      end
      a++;
      if (a == STOP * 256) a = START * 256;
    end
    chk(okd, "R4 payload placement and wrap", int'(okd), 1);
    if (len < 60) chk(okp, "R3 zero padding", int'(okp), 1);
    chk(wlog.size() == plen + 4 && wlog[wlog.size()-4] == base && wlog[wlog.size()-3] == base + 1 &&
        wlog[wlog.size()-2] == base + 2 && wlog[wlog.size()-1] == base + 3,
        "R8 header written last", wlog.size(), plen + 4);
    chk(int'(cur_pg) == nxt && !dbl && done_cnt == old + 1, "R9 current page and done pulse",
        int'(cur_pg), nxt);
    exp_cur = nxt;
  endtask

  task automatic space_case(input int cur, input int bnd, input bit exp, input string req);
    @(negedge clk);
    cur_ld = 1'b1; cur_ld_pg = 8'(cur); bnd_pg = 8'(bnd);
    @(negedge clk);
    cur_ld = 1'b0;
    repeat (3) @(negedge clk);
    chk(s_ready == exp, req, int'(s_ready), int'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vecs++; errs++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    rst = 1'b1; halt = 1'b1; cur_ld = 1'b0; cur_ld_pg = '0; s_valid = 1'b0;
    s_last = 1'b0; s_data = '0; start_pg = 8'(START); stop_pg = 8'(STOP); bnd_pg = 8'(START);
    repeat (3) @(negedge clk);
    chk(s_ready == 0 && mem_we == 0 && rx_done == 0 && cur_pg == 0, "R10 reset state",
        int'({s_ready, mem_we, rx_done}), 0);
    rst = 1'b0;
    @(negedge clk);
    cur_ld = 1'b1; cur_ld_pg = 8'(START);
    @(negedge clk);
    cur_ld = 1'b0;
    chk(int'(cur_pg) == START, "R11 current page load", int'(cur_pg), START);
    repeat (3) @(negedge clk);
    chk(s_ready == 1'b0, "R1 halt refuses frames", int'(s_ready), 0);
    halt = 1'b0;
    repeat (3) @(negedge clk);
    chk(s_ready == 1'b1, "R2 empty ring accepts", int'(s_ready), 1);
    exp_cur = START;
    send_frame(1, 1'b1);
    send_frame(59, 1'b0);
    send_frame(60, 1'b1);
    send_frame(61, 1'b0);
    send_frame(1514, 1'b1);
    send_frame(1514, 1'b0);
    for (int k = 0; k < 24; k++) begin
      int len;
      len = ($urandom % 8 == 0) ? 1514 : int'($urandom_range(1, 200));
      send_frame(len, 1'($urandom));
    end
    space_case(8'h48, 8'h41, 1'b0, "R2 wrapped free space 5 pages refused");
    space_case(8'h48, 8'h42, 1'b1, "R2 wrapped free space 6 pages accepted");
    space_case(8'h42, 8'h47, 1'b0, "R2 direct free space 5 pages refused");
    space_case(8'h42, 8'h48, 1'b1, "R2 direct free space 6 pages accepted");
    exp_cur = 8'h42;
    send_frame(300, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule